// File: doc/BRIEF.md
# Coprocessor Error Interrupt Gate

This block sits between a processor's legacy floating-point error pin and the system's interrupt logic. The processor signals a numeric error on an active-low line. A reporting-enable bit from a general control register gates the whole function.

While reporting is enabled, a pending error produces a level interrupt request on line 13. Software then writes the coprocessor error register. If that write comes while the error is still pending, the block drives the active-low ignore-error line back to the processor. That line holds until the error clears, and then releases by itself. A write made while no error is pending does nothing.

The error pin is asynchronous and passes through a synchroniser first. While the block is in reset, the ignore line carries a speed-strap value instead of its normal function.

Top module: `fpu_err_gate`

## Requirements
- R1: After `fp_err_n` goes low with `report_en` high, `irq13` stays 0 after the first rising clock edge and reads 1 after the second. The error path passes through a two-flop synchroniser.
- R2: `irq13` is a level. It falls two rising edges after `fp_err_n` returns high.
- R3: While `report_en` is 0, `irq13` is 0 and `ignore_err_n` is 1. Both take effect in the same cycle that `report_en` falls, without waiting for a clock edge.
- R4: A one-cycle `err_reg_wr` pulse, made while the synchronised error is active and `report_en` is 1, drives `ignore_err_n` to 0 after the next rising edge.
- R5: Once `ignore_err_n` is 0 it stays 0, whatever further writes arrive, until the synchronised error clears. It reads 1 two rising edges after `fp_err_n` returns high.
- R6: A write made while the synchronised error is inactive has no effect. `ignore_err_n` stays 1 even when an error arrives later.
- R7: While `rst_n` is 0, `irq13` is 0 and `ignore_err_n` equals `strap_ignore` (1 gives high, 0 gives low).
- R8: A write made while `report_en` is 0 is discarded. Setting `report_en` back to 1 does not assert `ignore_err_n`.
- R9: Suppose a write is accepted on the same edge at which the synchronised error clears. Then `ignore_err_n` stays 1, both in that cycle and afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_err_n | input | 1 | Asynchronous active-low numeric error from the processor |
| report_en | input | 1 | Coprocessor error reporting enable (control register bit) |
| err_reg_wr | input | 1 | One-cycle strobe for a write to the coprocessor error register |
| strap_ignore | input | 1 | Speed-strap value driven on the ignore line during reset |
| irq13 | output | 1 | Active-high level interrupt request on line 13 |
| ignore_err_n | output | 1 | Active-low ignore-numeric-error output to the processor |

## Verification
Two functions can meet on one clock edge: a register write setting the ignore state, and the synchroniser releasing the error. To provoke this, the bench raises `fp_err_n` and lets one edge pass, so the first flop is clear but the second still shows the error. It then strobes the write into the edge that clears the second flop. The ignore line must never fall, neither in that cycle nor in the following ones. A sweep over enable, error level and write then compares both outputs with expected values built from those three bits alone.

// File: rtl/fpu_err_pkg.sv
package fpu_err_pkg;

    // Default number of flops in the error synchroniser
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // Registered state of the ignore-output controller
    typedef struct packed {
        logic armed;
    } ign_state_t;

endpackage

// File: rtl/fpu_err_sync.sv
module fpu_err_sync #(
    parameter int unsigned STAGES = fpu_err_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = din;
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];

    // Checker state: how long din has held one value (reset counts as samples of 0)
    logic          last_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            run_q  <= '0;
        end else begin
            last_q <= din;
            if (din != last_q)              run_q <= '0;
            else if (run_q != CW'(STAGES))  run_q <= run_q + 1'b1;
        end
    end

    // R1
    sync_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CW'(STAGES)) |-> (dout == last_q));

endmodule

// File: rtl/fpu_err_ignore_ctrl.sv
module fpu_err_ignore_ctrl
    import fpu_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_s,
    input  logic report_en,
    input  logic reg_wr,
    output logic ign_active
);
    ign_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!report_en || !err_s) begin
            st_d.armed = 1'b0;
        end else if (reg_wr) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ign_active = st_q.armed & err_s & report_en;

    // R4
    arm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (report_en && err_s && reg_wr) |=> st_q.armed);

    // R5
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && err_s && report_en) |=> st_q.armed);

    // R6
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_s) |=> !st_q.armed);

    // R8
    disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!report_en) |=> !st_q.armed);

    // R9
    collide_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !err_s) |=> !st_q.armed);

endmodule

// File: rtl/fpu_err_gate.sv
module fpu_err_gate #(
    parameter int unsigned SYNC_STAGES = fpu_err_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_err_n,
    input  logic report_en,
    input  logic err_reg_wr,
    input  logic strap_ignore,
    output logic irq13,
    output logic ignore_err_n
);
    logic err_s;
    logic ign_active;

    fpu_err_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (~fp_err_n),
        .dout  (err_s)
    );

    fpu_err_ignore_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_s      (err_s),
        .report_en  (report_en),
        .reg_wr     (err_reg_wr),
        .ign_active (ign_active)
    );

    assign irq13        = report_en & err_s;
    assign ignore_err_n = rst_n ? ~ign_active : strap_ignore;

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!report_en) |-> (!irq13 && ignore_err_n));

    // R5
    ignore_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ignore_err_n) |-> irq13);

endmodule

// File: tb/fpu_err_gate_test.sv
module fpu_err_gate_test;
    logic clk = 1'b0;
    logic rst_n, fp_err_n, report_en, err_reg_wr, strap_ignore;
    logic irq13, ignore_err_n;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fpu_err_gate uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fp_err_n     (fp_err_n),
        .report_en    (report_en),
        .err_reg_wr   (err_reg_wr),
        .strap_ignore (strap_ignore),
        .irq13        (irq13),
        .ignore_err_n (ignore_err_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_wr();
        err_reg_wr = 1'b1;
        step(1);
        err_reg_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fp_err_n = 1'b0; report_en = 1'b1;
        err_reg_wr = 1'b0; strap_ignore = 1'b1;
        step(2);
        chk("R7 strap high", ignore_err_n, 1'b1);
        chk("R7 irq in reset", irq13, 1'b0);
        strap_ignore = 1'b0; #1;
        chk("R7 strap low", ignore_err_n, 1'b0);
        fp_err_n = 1'b1;
        step(1);
        rst_n = 1'b1;
        step(3);
        chk("R7 after reset", ignore_err_n, 1'b1);

        // R1 latency
        fp_err_n = 1'b0;
        step(1);
        chk("R1 one edge", irq13, 1'b0);
        step(1);
        chk("R1 two edges", irq13, 1'b1);

        // R4 write while error pending
        pulse_wr();
        chk("R4 ignore set", ignore_err_n, 1'b0);

        // R5 hold, extra write, release
        pulse_wr();
        chk("R5 hold after rewrite", ignore_err_n, 1'b0);
        fp_err_n = 1'b1;
        step(1);
        chk("R5 held one edge", ignore_err_n, 1'b0);
        chk("R2 irq one edge", irq13, 1'b1);
        step(1);
        chk("R5 released", ignore_err_n, 1'b1);
        chk("R2 irq dropped", irq13, 1'b0);

        // R6 write with no error
        pulse_wr();
        chk("R6 idle write", ignore_err_n, 1'b1);
        fp_err_n = 1'b0;
        step(3);
        chk("R6 later error", ignore_err_n, 1'b1);
        chk("R6 irq up", irq13, 1'b1);

        // R3 enable drop is immediate
        pulse_wr();
        chk("R3 precondition", ignore_err_n, 1'b0);
        report_en = 1'b0; #1;
        chk("R3 irq gated", irq13, 1'b0);
        chk("R3 ignore gated", ignore_err_n, 1'b1);
        step(1);
        report_en = 1'b1; #1;
        chk("R3 no re-arm", ignore_err_n, 1'b1);

        // R8 write while disabled
        report_en = 1'b0;
        pulse_wr();
        report_en = 1'b1;
        step(2);
        chk("R8 disabled write", ignore_err_n, 1'b1);
        chk("R8 irq back", irq13, 1'b1);

        // R9 write coincides with synchroniser release
        fp_err_n = 1'b1;
        step(1);
        chk("R9 second flop still set", irq13, 1'b1);
        pulse_wr();
        chk("R9 same cycle", ignore_err_n, 1'b1);
        step(1);
        chk("R9 after", ignore_err_n, 1'b1);

        // Sweep: enable x error x write
        for (int k = 0; k < 8; k++) begin
            logic en, er, wr;
            en = k[2]; er = k[1]; wr = k[0];
            report_en = 1'b0;
            fp_err_n  = 1'b1;
            step(3);
            fp_err_n  = ~er;
            step(3);
            report_en = en;
            if (wr) pulse_wr(); else step(1);
            chk("R4 sweep ignore", ignore_err_n, ~(en & er & wr));
            chk("R2 sweep irq", irq13, en & er);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule